// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the pointer state of an outbound descriptor ring for each of up to sixteen queues. For every queue it holds a 64-bit ring base, a ring length counted in descriptors, and four ring pointers. The head is the next descriptor the prefetch logic will read. The tail is the first slot software has not yet published. The current pointer is the next prefetched descriptor handed to the data path. The optional data-tail pointer marks how far descriptor data is ready. Software moves the tail only by writing an increment to a doorbell. It cannot write the tail as an absolute value.

The prefetcher is modelled as a consume strobe. It carries a queue number, a descriptor count and the generation bit it found in the fetched descriptor. The head advances when that bit matches the low bit of the head's 2-bit generation tag. A mismatch is rejected, and a ring-id error is reported unless that queue masks it. A separate issue strobe moves the current pointer by one descriptor. The pointer may not pass the head, and with enhanced prefetch enabled it may not pass the data tail either. Every pointer wraps modulo the ring length, and its tag goes up by one on each wrap. Per-queue full and idle flags and a readable status word give the fill level.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset every pointer of every queue reads 0x40000000 (offset 0, tag 1 in bits [31:30], bits [29:24] zero). Every status word reads 0x40000000, meaning idle and not full.
- R2: Register writes use cfg_sel codes 0 base-low, 1 base-high, 2 length, 3 doorbell, 4 data doorbell, 5 control (bit0 enhanced prefetch, bit1 error mask) and 6 reset strobes. Reads use rd_sel codes 0 base-low, 1 base-high, 2 length, 3 head, 4 tail, 5 current, 6 data tail, 7 status and 8 control. Base-low bits [5:0] always read zero, and base-high keeps all 32 bits.
- R3: Writing N to the doorbell adds N to the tail one cycle later. The fill level, which is tail minus head, rises by N.
- R4: A doorbell N that exceeds the free space (length minus fill) is clamped, so the fill equals the length and the full flag sets. The fill never exceeds the length.
- R5: Pointers wrap modulo the ring length. Each wrap adds one to the 2-bit tag, and tag 3 rolls over to 0.
- R6: A consume strobe whose generation bit matches advances the head by min(count, fill). The queue is idle when the fill is zero.
- R7: A consume whose generation bit differs from the head tag's bit 0 leaves the head unchanged. On the next cycle ring_err pulses for one cycle with the queue number in ring_err_q, unless control bit1 of that queue is set.
- R8: An issue strobe is granted in the same cycle, and advances the current pointer by one, only while the current pointer is behind the head.
- R9: With enhanced prefetch on, an issue also needs the current pointer to be behind the data tail. The data doorbell advances the data tail by N, clamped so that it never passes the tail.
- R10: Reset-strobe bits in the code-6 write set pointers back to offset 0, tag 1. Bit0 resets all four pointers, bit1 the head, bit2 the tail, bit3 the current pointer and bit4 the data tail.
- R11: The status word holds full in bit 31, idle in bit 30 and the fill in bits [24:0]. q_full and q_idle carry the same flags for every queue.
- R12: An operation on one queue leaves the pointers of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_q | input | 4 | Queue addressed by the write |
| cfg_sel | input | 4 | Write target code |
| cfg_wdata | input | 32 | Write data |
| rd_q | input | 4 | Queue addressed by the read |
| rd_sel | input | 4 | Read target code |
| rd_data | output | 32 | Combinational read data |
| cons_valid | input | 1 | Prefetch consume strobe |
| cons_q | input | 4 | Consuming queue |
| cons_cnt | input | 24 | Descriptors read |
| cons_gen | input | 1 | Generation bit found in the descriptor |
| iss_valid | input | 1 | Issue request for the data path |
| iss_q | input | 4 | Issuing queue |
| iss_grant | output | 1 | Issue accepted this cycle |
| ring_err | output | 1 | Ring-id mismatch pulse |
| ring_err_q | output | 4 | Queue of the reported mismatch |
| q_full | output | 16 | Per-queue full flag |
| q_idle | output | 16 | Per-queue idle flag |

## Verification
The assertions check, on every cycle, the invariants that must hold for each queue. The fill never exceeds the length. Full and idle never hold together. A doorbell with no competing consume never lowers the fill. Grants and error pulses only follow their own strobes. Read data always shows zeroed base-low bits and reserved pointer bits. Only the scenarios can show exact values: the clamped tail offsets, tag changes on wrap including the 3-to-0 rollover, masked versus unmasked rejection, the data-tail gate on issue, the effect of each reset strobe, and isolation between queues.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int OFS_W    = 24;
  localparam int GEN_W    = 2;
  localparam int CNT_W    = OFS_W + 1;
  localparam int BASE_LSB = 6;
  localparam int PAD_W    = 32 - GEN_W - OFS_W;

  typedef struct packed {
    logic [GEN_W-1:0] gen;
    logic [OFS_W-1:0] off;
  } rptr_t;

  localparam rptr_t PTR_INIT = '{gen: GEN_W'(1), off: '0};

  typedef enum logic [3:0] {
    W_BASE_LO = 4'd0, W_BASE_HI = 4'd1, W_LEN = 4'd2, W_DOORBELL = 4'd3,
    W_DDOORBELL = 4'd4, W_CTRL = 4'd5, W_STROBE = 4'd6
  } wsel_e;

  typedef enum logic [3:0] {
    RD_BASE_LO = 4'd0, RD_BASE_HI = 4'd1, RD_LEN = 4'd2, RD_HEAD = 4'd3,
    RD_TAIL = 4'd4, RD_CUR = 4'd5, RD_DTAIL = 4'd6, RD_STATUS = 4'd7,
    RD_CTRL = 4'd8
  } rsel_e;

  localparam int STB_ALL   = 0;
  localparam int STB_HEAD  = 1;
  localparam int STB_TAIL  = 2;
  localparam int STB_CUR   = 3;
  localparam int STB_DTAIL = 4;

  // distance from lag forward to lead; equal offsets are told apart by tag
  function automatic logic [CNT_W-1:0] span(rptr_t lead, rptr_t lag,
                                            logic [OFS_W-1:0] len);
    logic [CNT_W-1:0] d;
    if (lead.off > lag.off)
      d = {1'b0, lead.off} - {1'b0, lag.off};
    else if (lead.off < lag.off)
      d = {1'b0, len} + {1'b0, lead.off} - {1'b0, lag.off};
    else
      d = (lead.gen == lag.gen) ? '0 : {1'b0, len};
    return d;
  endfunction

  function automatic rptr_t advance(rptr_t p, logic [OFS_W-1:0] n,
                                    logic [OFS_W-1:0] len);
    logic [CNT_W-1:0] s;
    rptr_t r;
    s = {1'b0, p.off} + {1'b0, n};
    r = p;
    if (n != '0 && s >= {1'b0, len}) begin
      s     = s - {1'b0, len};
      r.gen = p.gen + GEN_W'(1);
    end
    r.off = s[OFS_W-1:0];
    return r;
  endfunction

  function automatic logic [OFS_W-1:0] clamp(logic [OFS_W-1:0] want,
                                             logic [CNT_W-1:0] lim);
    return ({1'b0, want} > lim) ? lim[OFS_W-1:0] : want;
  endfunction

  function automatic logic [31:0] ptr_word(rptr_t p);
    return {p.gen, {PAD_W{1'b0}}, p.off};
  endfunction
endpackage

// File: rtl/rpm_queue.sv
module rpm_queue
  import rpm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [3:0]              wr_sel,
  input  logic [31:0]             wr_data,
  input  logic                    cons_en,
  input  logic [OFS_W-1:0]        cons_cnt,
  input  logic                    cons_gen,
  input  logic                    iss_en,
  output rptr_t                   head,
  output rptr_t                   tail,
  output rptr_t                   cur,
  output rptr_t                   dtail,
  output logic [31-BASE_LSB:0]    base_lo,
  output logic [31:0]             base_hi,
  output logic [OFS_W-1:0]        len,
  output logic                    enh,
  output logic                    err_mask,
  output logic [CNT_W-1:0]        used,
  output logic                    full,
  output logic                    idle,
  output logic                    iss_ok,
  output logic                    gen_bad
);
  rptr_t                 head_n, tail_n, cur_n, dtail_n;
  logic [31-BASE_LSB:0]  base_lo_n;
  logic [31:0]           base_hi_n;
  logic [OFS_W-1:0]      len_n;
  logic                  enh_n, err_mask_n;
  logic [CNT_W-1:0]      room;
  logic                  upd_en;

  assign upd_en = wr_en | cons_en | iss_en;

  always_comb begin
    used    = span(tail, head, len);
    room    = {1'b0, len} - used;
    full    = (len != '0) && (used == {1'b0, len});
    idle    = (used == '0);
    gen_bad = (cons_gen != head.gen[0]);
    iss_ok  = (span(head, cur, len) != '0) &&
              (!enh || (span(dtail, cur, len) != '0));

    head_n     = head;
    tail_n     = tail;
    cur_n      = cur;
    dtail_n    = dtail;
    base_lo_n  = base_lo;
    base_hi_n  = base_hi;
    len_n      = len;
    enh_n      = enh;
    err_mask_n = err_mask;

    if (cons_en && !gen_bad)
      head_n = advance(head, clamp(cons_cnt, used), len);
    if (iss_en && iss_ok)
      cur_n = advance(cur, OFS_W'(1), len);

    if (wr_en) begin
      case (wr_sel)
        W_BASE_LO:   base_lo_n = wr_data[31:BASE_LSB];
        W_BASE_HI:   base_hi_n = wr_data;
        W_LEN:       len_n = wr_data[OFS_W-1:0];
        W_DOORBELL:  tail_n = advance(tail, clamp(wr_data[OFS_W-1:0], room), len);
        W_DDOORBELL: dtail_n = advance(dtail,
                        clamp(wr_data[OFS_W-1:0], span(tail, dtail, len)), len);
        W_CTRL: begin
          enh_n      = wr_data[0];
          err_mask_n = wr_data[1];
        end
        W_STROBE: begin
          if (wr_data[STB_ALL] || wr_data[STB_HEAD])  head_n  = PTR_INIT;
          if (wr_data[STB_ALL] || wr_data[STB_TAIL])  tail_n  = PTR_INIT;
          if (wr_data[STB_ALL] || wr_data[STB_CUR])   cur_n   = PTR_INIT;
          if (wr_data[STB_ALL] || wr_data[STB_DTAIL]) dtail_n = PTR_INIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= PTR_INIT;
      tail     <= PTR_INIT;
      cur      <= PTR_INIT;
      dtail    <= PTR_INIT;
      base_lo  <= '0;
      base_hi  <= '0;
      len      <= '0;
      enh      <= 1'b0;
      err_mask <= 1'b0;
    end else if (upd_en) begin
      head     <= head_n;
      tail     <= tail_n;
      cur      <= cur_n;
      dtail    <= dtail_n;
      base_lo  <= base_lo_n;
      base_hi  <= base_hi_n;
      len      <= len_n;
      enh      <= enh_n;
      err_mask <= err_mask_n;
    end
  end
endmodule

// File: rtl/rpm_readmux.sv
module rpm_readmux
  import rpm_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic [QW-1:0]                    rd_q,
  input  logic [3:0]                       rd_sel,
  input  rptr_t [NUM_Q-1:0]                head_v,
  input  rptr_t [NUM_Q-1:0]                tail_v,
  input  rptr_t [NUM_Q-1:0]                cur_v,
  input  rptr_t [NUM_Q-1:0]                dtail_v,
  input  logic [NUM_Q-1:0][31-BASE_LSB:0]  base_lo_v,
  input  logic [NUM_Q-1:0][31:0]           base_hi_v,
  input  logic [NUM_Q-1:0][OFS_W-1:0]      len_v,
  input  logic [NUM_Q-1:0]                 enh_v,
  input  logic [NUM_Q-1:0]                 mask_v,
  input  logic [NUM_Q-1:0][CNT_W-1:0]      used_v,
  input  logic [NUM_Q-1:0]                 full_v,
  input  logic [NUM_Q-1:0]                 idle_v,
  output logic [31:0]                      rd_data
);
  localparam int STAT_PAD = 32 - 2 - CNT_W;

  always_comb begin
    case (rd_sel)
      RD_BASE_LO: rd_data = {base_lo_v[rd_q], {BASE_LSB{1'b0}}};
      RD_BASE_HI: rd_data = base_hi_v[rd_q];
      RD_LEN:     rd_data = {{(32-OFS_W){1'b0}}, len_v[rd_q]};
      RD_HEAD:    rd_data = ptr_word(head_v[rd_q]);
      RD_TAIL:    rd_data = ptr_word(tail_v[rd_q]);
      RD_CUR:     rd_data = ptr_word(cur_v[rd_q]);
      RD_DTAIL:   rd_data = ptr_word(dtail_v[rd_q]);
      RD_STATUS:  rd_data = {full_v[rd_q], idle_v[rd_q], {STAT_PAD{1'b0}}, used_v[rd_q]};
      RD_CTRL:    rd_data = {30'd0, mask_v[rd_q], enh_v[rd_q]};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import rpm_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_q,
  input  logic [3:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [QW-1:0]     rd_q,
  input  logic [3:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic              cons_valid,
  input  logic [QW-1:0]     cons_q,
  input  logic [OFS_W-1:0]  cons_cnt,
  input  logic              cons_gen,
  input  logic              iss_valid,
  input  logic [QW-1:0]     iss_q,
  output logic              iss_grant,
  output logic              ring_err,
  output logic [QW-1:0]     ring_err_q,
  output logic [NUM_Q-1:0]  q_full,
  output logic [NUM_Q-1:0]  q_idle
);
  rptr_t [NUM_Q-1:0]                head_v, tail_v, cur_v, dtail_v;
  logic  [NUM_Q-1:0][31-BASE_LSB:0] base_lo_v;
  logic  [NUM_Q-1:0][31:0]          base_hi_v;
  logic  [NUM_Q-1:0][OFS_W-1:0]     len_v;
  logic  [NUM_Q-1:0][CNT_W-1:0]     used_v;
  logic  [NUM_Q-1:0]                enh_v, mask_v, iss_ok_v, gen_bad_v;
  logic                             err_n;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    rpm_queue u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_q == QW'(q))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .cons_en  (cons_valid && (cons_q == QW'(q))),
      .cons_cnt (cons_cnt),
      .cons_gen (cons_gen),
      .iss_en   (iss_valid && (iss_q == QW'(q))),
      .head     (head_v[q]),
      .tail     (tail_v[q]),
      .cur      (cur_v[q]),
      .dtail    (dtail_v[q]),
      .base_lo  (base_lo_v[q]),
      .base_hi  (base_hi_v[q]),
      .len      (len_v[q]),
      .enh      (enh_v[q]),
      .err_mask (mask_v[q]),
      .used     (used_v[q]),
      .full     (q_full[q]),
      .idle     (q_idle[q]),
      .iss_ok   (iss_ok_v[q]),
      .gen_bad  (gen_bad_v[q])
    );
  end

  rpm_readmux #(.NUM_Q(NUM_Q)) u_rd (
    .rd_q      (rd_q),
    .rd_sel    (rd_sel),
    .head_v    (head_v),
    .tail_v    (tail_v),
    .cur_v     (cur_v),
    .dtail_v   (dtail_v),
    .base_lo_v (base_lo_v),
    .base_hi_v (base_hi_v),
    .len_v     (len_v),
    .enh_v     (enh_v),
    .mask_v    (mask_v),
    .used_v    (used_v),
    .full_v    (q_full),
    .idle_v    (q_idle),
    .rd_data   (rd_data)
  );

  assign iss_grant = iss_valid && iss_ok_v[iss_q];
  assign err_n     = cons_valid && gen_bad_v[cons_q] && !mask_v[cons_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_err   <= 1'b0;
      ring_err_q <= '0;
    end else begin
      ring_err <= err_n;
      if (err_n) ring_err_q <= cons_q;
    end
  end
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker
  import rpm_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QW = $clog2(NUM_Q)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [QW-1:0]                 cfg_q,
  input logic [3:0]                    cfg_sel,
  input logic [3:0]                    rd_sel,
  input logic [31:0]                   rd_data,
  input logic                          cons_valid,
  input logic [QW-1:0]                 cons_q,
  input logic                          iss_valid,
  input logic                          iss_grant,
  input logic                          ring_err,
  input logic [NUM_Q-1:0]              q_full,
  input logic [NUM_Q-1:0]              q_idle,
  input logic [NUM_Q-1:0][CNT_W-1:0]   used_v,
  input logic [NUM_Q-1:0][OFS_W-1:0]   len_v
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
    assert_fill_le_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      used_v[q] <= {1'b0, len_v[q]});
    assert_full_idle_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full[q] && q_idle[q]));
    assert_doorbell_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_q == QW'(q) && cfg_sel == W_DOORBELL &&
       !(cons_valid && cons_q == QW'(q)))
      |=> used_v[q] >= $past(used_v[q]));
  end

  assert_err_after_consume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_err |-> $past(cons_valid));
  assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> iss_valid);
  assert_base_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == RD_BASE_LO) |-> (rd_data[BASE_LSB-1:0] == '0));
  assert_ptr_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= RD_HEAD && rd_sel <= RD_DTAIL) |-> (rd_data[29:OFS_W] == '0));
endmodule

bind ring_ptr_mgr rpm_checker #(.NUM_Q(NUM_Q)) u_rpm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_q      (cfg_q),
  .cfg_sel    (cfg_sel),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .cons_valid (cons_valid),
  .cons_q     (cons_q),
  .iss_valid  (iss_valid),
  .iss_grant  (iss_grant),
  .ring_err   (ring_err),
  .q_full     (q_full),
  .q_idle     (q_idle),
  .used_v     (used_v),
  .len_v      (len_v)
);

// File: tb/ring_ptr_mgr_test.sv
module ring_ptr_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_q = '0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  rd_q = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        cons_valid = 1'b0;
  logic [3:0]  cons_q = '0;
  logic [23:0] cons_cnt = '0;
  logic        cons_gen = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_q = '0;
  logic        iss_grant, ring_err;
  logic [3:0]  ring_err_q;
  logic [15:0] q_full, q_idle;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ring_ptr_mgr uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(int q, int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_q = 4'(q); cfg_sel = 4'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int q, int sel, output logic [31:0] v);
    rd_q = 4'(q); rd_sel = 4'(sel);
    #1 v = rd_data;
  endtask

  task automatic cons(int q, int cnt, bit g, output logic e, output logic [3:0] eq);
    @(negedge clk);
    cons_valid = 1'b1; cons_q = 4'(q); cons_cnt = 24'(cnt); cons_gen = g;
    @(negedge clk);
    cons_valid = 1'b0;
    e = ring_err; eq = ring_err_q;
  endtask

  task automatic iss(int q, output logic g);
    @(negedge clk);
    iss_valid = 1'b1; iss_q = 4'(q);
    #1 g = iss_grant;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 3, v); chk("R1 head", v, 32'h4000_0000);
    rd(9, 6, v); chk("R1 dtail", v, 32'h4000_0000);
    rd(0, 7, v); chk("R1 status", v, 32'h4000_0000);
    chk("R11 idle vec", 32'(q_idle), 32'h0000_FFFF);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, v); chk("R2 base lo", v, 32'hFFFF_FFC0);
    wr(1, 1, 32'h1234_5678);
    rd(1, 1, v); chk("R2 base hi", v, 32'h1234_5678);
  endtask

  task automatic t_doorbell_clamp_consume();
    logic [31:0] v; logic e; logic [3:0] eq;
    wr(2, 2, 32'd8);
    wr(2, 3, 32'd3);
    rd(2, 4, v); chk("R3 tail", v, 32'h4000_0003);
    wr(2, 3, 32'd2);
    rd(2, 7, v); chk("R3 fill", v, 32'h0000_0005);
    wr(2, 3, 32'd10);
    rd(2, 7, v); chk("R4 clamp full", v, 32'h8000_0008);
    rd(2, 4, v); chk("R5 tail wrap", v, 32'h8000_0000);
    chk("R11 full vec", 32'(q_full[2]), 32'd1);
    cons(2, 5, 1'b1, e, eq);
    rd(2, 3, v); chk("R6 head", v, 32'h4000_0005);
    rd(2, 7, v); chk("R6 fill", v, 32'h0000_0003);
    cons(2, 10, 1'b1, e, eq);
    rd(2, 3, v); chk("R6 head clamp", v, 32'h8000_0000);
    rd(2, 7, v); chk("R6 idle", v, 32'h4000_0000);
  endtask

  task automatic t_gen_err();
    logic [31:0] v; logic e; logic [3:0] eq;
    wr(2, 3, 32'd2);
    cons(2, 1, 1'b1, e, eq);
    chk("R7 err pulse", {31'd0, e}, 32'd1);
    chk("R7 err queue", 32'(eq), 32'd2);
    rd(2, 3, v); chk("R7 head held", v, 32'h8000_0000);
    @(negedge clk);
    chk("R7 single pulse", {31'd0, ring_err}, 32'd0);
    wr(2, 5, 32'h2);
    cons(2, 1, 1'b1, e, eq);
    chk("R7 masked", {31'd0, e}, 32'd0);
    cons(2, 1, 1'b0, e, eq);
    rd(2, 3, v); chk("R7 match ok", v, 32'h8000_0001);
  endtask

  task automatic t_issue();
    logic [31:0] v; logic g; logic e; logic [3:0] eq;
    wr(3, 2, 32'd4);
    wr(3, 3, 32'd2);
    iss(3, g); chk("R8 no grant at head", {31'd0, g}, 32'd0);
    cons(3, 1, 1'b1, e, eq);
    iss(3, g); chk("R8 grant", {31'd0, g}, 32'd1);
    rd(3, 5, v); chk("R8 cur", v, 32'h4000_0001);
    iss(3, g); chk("R8 stop at head", {31'd0, g}, 32'd0);
  endtask

  task automatic t_enhanced();
    logic [31:0] v; logic g; logic e; logic [3:0] eq;
    wr(4, 2, 32'd4);
    wr(4, 5, 32'h1);
    wr(4, 3, 32'd3);
    cons(4, 3, 1'b1, e, eq);
    iss(4, g); chk("R9 gated by dtail", {31'd0, g}, 32'd0);
    wr(4, 4, 32'd1);
    rd(4, 6, v); chk("R9 dtail", v, 32'h4000_0001);
    iss(4, g); chk("R9 grant", {31'd0, g}, 32'd1);
    iss(4, g); chk("R9 gated again", {31'd0, g}, 32'd0);
    wr(4, 4, 32'd10);
    rd(4, 6, v); chk("R9 dtail clamp", v, 32'h4000_0003);
  endtask

  task automatic t_rollover();
    logic [31:0] v; logic e; logic [3:0] eq;
    wr(5, 2, 32'd1);
    wr(5, 3, 32'd1);
    cons(5, 1, 1'b1, e, eq);
    wr(5, 3, 32'd1);
    cons(5, 1, 1'b0, e, eq);
    rd(5, 3, v); chk("R5 head tag3", v, 32'hC000_0000);
    wr(5, 3, 32'd1);
    rd(5, 4, v); chk("R5 tag roll", v, 32'h0000_0000);
  endtask

  task automatic t_strobes();
    logic [31:0] v;
    wr(3, 6, 32'h2);
    rd(3, 3, v); chk("R10 head strobe", v, 32'h4000_0000);
    rd(3, 4, v); chk("R10 tail kept", v, 32'h4000_0002);
    wr(4, 6, 32'h1);
    rd(4, 5, v); chk("R10 all cur", v, 32'h4000_0000);
    rd(4, 7, v); chk("R10 all idle", v, 32'h4000_0000);
    rd(6, 4, v); chk("R12 untouched", v, 32'h4000_0000);
    rd(2, 3, v); chk("R12 other queue", v, 32'h8000_0001);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_doorbell_clamp_consume();
    t_gen_err();
    t_issue();
    t_enhanced();
    t_rollover();
    t_strobes();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule